// File: doc/BRIEF.md
# Enable-Triggered Housekeeping ADC Controller

This block holds the digital control for a slow 8-bit successive-approximation converter that measures DC levels such as battery voltage or temperature. The converter stays powered down until an enable input rises. On that rise the controller powers the analog part up and holds the sample-and-hold open for a set time. It then runs a binary search: it drives a trial code to the internal DAC and reads back a single comparator bit. When the search ends, it shifts the result out on a serial data line, MSB first, with a serial clock it makes by dividing the reference clock.

The enable input is asynchronous. It passes through a two-flop synchronizer before its rising edge is detected. A rising edge that comes while a conversion is running is dropped and not remembered. Another conversion starts only after the current one has finished and enable has been seen low and then high again. The codes are offset binary, so 0x80 is mid-scale and is also the first trial code.

Top module: `hk_adc_ctrl`

## Requirements
- R1: During and straight after synchronous reset, `pwr_up_o`, `sample_o`, `busy_o`, `sclk_o` and `sdata_o` are 0 and `dac_code_o` is 0x80.
- R2: While idle, a rise on `en_i` is accepted on the third rising clock edge after the first edge that samples `en_i` high. `busy_o` and `pwr_up_o` are 1 from that edge on (two synchronizer stages).
- R3: `busy_o` and `pwr_up_o` stay 1 for PWRUP_CYC + SAMPLE_CYC + DATA_W*BIT_CYC + DATA_W*SCLK_DIV cycles after the accept edge, then both return to 0.
- R4: `sample_o` is 1 for exactly SAMPLE_CYC cycles, starting PWRUP_CYC cycles after the accept edge, and is 0 at all other times.
- R5: `dac_code_o` is 0x80 from the accept edge through the sample phase. Trial k (k = 0 is the MSB) is shown for BIT_CYC cycles. On the last cycle of a trial, `cmp_i` = 1 keeps the bit under test and 0 clears it, and the next lower bit is set for the next trial.
- R6: After the last trial, `dac_code_o` holds the result until the next accepted start.
- R7: The result is sent MSB first on `sdata_o`. Each bit lasts SCLK_DIV cycles, and the bits follow the search with no gap. `sdata_o` changes only while `sclk_o` is low, and it is 0 outside the serial phase.
- R8: In each bit period `sclk_o` is 0 for the first SCLK_DIV/2 cycles and 1 for the last SCLK_DIV/2. It is 0 outside the serial phase. SCLK_DIV must be even.
- R9: An enable rise while `busy_o` is 1 is ignored. It does not start a conversion, now or after the current one ends.
- R10: If `en_i` is still high when a conversion ends, no new conversion starts until `en_i` has gone low and risen again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Asynchronous conversion request, acts on its rising edge |
| cmp_i | input | 1 | Comparator: 1 when the held input is at or above the trial code |
| pwr_up_o | output | 1 | Analog power-up |
| sample_o | output | 1 | Sample-and-hold track control |
| dac_code_o | output | DATA_W | Trial code, and the held result after the search |
| sclk_o | output | 1 | Serial clock, driven only while data is sent |
| sdata_o | output | 1 | Serial result, MSB first |
| busy_o | output | 1 | Conversion in progress |

## Verification
The bench builds the block with DATA_W = 8, SCLK_DIV = 8, PWRUP_CYC = 5, SAMPLE_CYC = 3 and BIT_CYC = 2. These short, unequal phase lengths keep one conversion under a hundred cycles, so many input codes fit in one run, and they expose off-by-one errors at each phase boundary. Its comparator answers from a held input value, so codes 0x00, 0xFF, 0x7F, 0x80 and mixed patterns drive every keep and clear decision. Enable toggles during a conversion, enable held high across completion, and a one-cycle enable pulse test the start rules.

// File: rtl/hk_adc_pkg.sv
package hk_adc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PWRUP,
    ST_SAMPLE,
    ST_CONV,
    ST_SHIFT
  } hk_state_t;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/hk_en_sync.sv
module hk_en_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  output logic level_o,
  output logic rise_o
);

  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], en_i};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign level_o = chain_q[STAGES-1];
  assign rise_o  = chain_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/hk_sar_search.sv
module hk_sar_search #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         init_i,
  input  logic         step_i,
  input  logic         cmp_i,
  output logic [W-1:0] code_o,
  output logic [W-1:0] code_nxt_o
);

  localparam logic [W-1:0] MID = W'(1) << (W - 1);

  logic [W-1:0] code_q;
  logic [W-1:0] mask_q;
  logic [W-1:0] kept;

  // The bit under test is kept when the comparator says input >= trial.
  assign kept       = cmp_i ? code_q : (code_q & ~mask_q);
  assign code_nxt_o = kept | (mask_q >> 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= MID;
      mask_q <= '0;
    end else if (init_i) begin
      code_q <= MID;
      mask_q <= MID;
    end else if (step_i) begin
      code_q <= code_nxt_o;
      mask_q <= mask_q >> 1;
    end
  end

  assign code_o = code_q;

endmodule

// File: rtl/hk_ser_tx.sv
module hk_ser_tx #(
  parameter int W   = 8,
  parameter int DIV = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] data_i,
  output logic         sclk_o,
  output logic         sdata_o,
  output logic         last_o
);

  localparam int PW   = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int BW   = (W > 1) ? $clog2(W) : 1;
  localparam int HALF = DIV / 2;

  logic [PW-1:0] phase_q;
  logic [BW-1:0] bit_q;
  logic [W-1:0]  sreg_q;
  logic          act_q;
  logic          sclk_q;
  logic [PW:0]   ph_nx;
  logic          period_end;

  assign ph_nx      = {1'b0, phase_q} + 1'b1;
  assign period_end = (phase_q == PW'(DIV - 1));
  assign last_o     = act_q & period_end & (bit_q == BW'(W - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
      bit_q   <= '0;
      sreg_q  <= '0;
      act_q   <= 1'b0;
      sclk_q  <= 1'b0;
    end else if (load_i) begin
      phase_q <= '0;
      bit_q   <= '0;
      sreg_q  <= data_i;
      act_q   <= 1'b1;
      sclk_q  <= 1'b0;
    end else if (act_q) begin
      if (period_end) begin
        phase_q <= '0;
        sclk_q  <= 1'b0;
        if (last_o) begin
          act_q  <= 1'b0;
          sreg_q <= '0;
        end else begin
          bit_q  <= bit_q + 1'b1;
          sreg_q <= sreg_q << 1;
        end
      end else begin
        phase_q <= ph_nx[PW-1:0];
        sclk_q  <= (ph_nx >= (PW+1)'(HALF));
      end
    end
  end

  assign sclk_o  = sclk_q;
  assign sdata_o = sreg_q[W-1];

endmodule

// File: rtl/hk_adc_ctrl.sv
module hk_adc_ctrl
  import hk_adc_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SCLK_DIV    = 24,
  parameter int PWRUP_CYC   = 24,
  parameter int SAMPLE_CYC  = 24,
  parameter int BIT_CYC     = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_i,
  input  logic              cmp_i,
  output logic              pwr_up_o,
  output logic              sample_o,
  output logic [DATA_W-1:0] dac_code_o,
  output logic              sclk_o,
  output logic              sdata_o,
  output logic              busy_o
);

  localparam int MAXC  = max3(PWRUP_CYC, SAMPLE_CYC, BIT_CYC);
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam int TR_W  = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  hk_state_t          state_q, state_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [TR_W-1:0]    trial_q, trial_d;
  logic               busy_q, pwr_q, samp_q;
  logic               en_rise, en_level;
  logic               sar_init, sar_step, ser_load, ser_last;
  logic [DATA_W-1:0]  code_nxt;

  hk_en_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .en_i    (en_i),
    .level_o (en_level),
    .rise_o  (en_rise)
  );

  hk_sar_search #(.W(DATA_W)) u_sar (
    .clk        (clk),
    .rst        (rst),
    .init_i     (sar_init),
    .step_i     (sar_step),
    .cmp_i      (cmp_i),
    .code_o     (dac_code_o),
    .code_nxt_o (code_nxt)
  );

  hk_ser_tx #(.W(DATA_W), .DIV(SCLK_DIV)) u_ser (
    .clk     (clk),
    .rst     (rst),
    .load_i  (ser_load),
    .data_i  (code_nxt),
    .sclk_o  (sclk_o),
    .sdata_o (sdata_o),
    .last_o  (ser_last)
  );

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    trial_d  = trial_q;
    sar_init = 1'b0;
    sar_step = 1'b0;
    ser_load = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        // Only an edge seen while idle starts a conversion; others are dropped.
        if (en_rise) begin
          state_d  = ST_PWRUP;
          cnt_d    = '0;
          sar_init = 1'b1;
        end
      end
      ST_PWRUP: begin
        if (cnt_q == CNT_W'(PWRUP_CYC - 1)) begin
          state_d = ST_SAMPLE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_SAMPLE: begin
        if (cnt_q == CNT_W'(SAMPLE_CYC - 1)) begin
          state_d = ST_CONV;
          cnt_d   = '0;
          trial_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_CONV: begin
        if (cnt_q == CNT_W'(BIT_CYC - 1)) begin
          sar_step = 1'b1;
          cnt_d    = '0;
          if (trial_q == TR_W'(DATA_W - 1)) begin
            state_d  = ST_SHIFT;
            ser_load = 1'b1;
          end else begin
            trial_d = trial_q + 1'b1;
          end
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_SHIFT: begin
        if (ser_last) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      trial_q <= '0;
      busy_q  <= 1'b0;
      pwr_q   <= 1'b0;
      samp_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      trial_q <= trial_d;
      busy_q  <= (state_d != ST_IDLE);
      pwr_q   <= (state_d != ST_IDLE);
      samp_q  <= (state_d == ST_SAMPLE);
    end
  end

  assign busy_o   = busy_q;
  assign pwr_up_o = pwr_q;
  assign sample_o = samp_q;

  // The synchronized level is consumed only through the edge detector.
  logic unused_level;
  assign unused_level = en_level;

endmodule

// File: rtl/hk_adc_ctrl_chk.sv
module hk_adc_ctrl_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         en_i,
  input logic         busy_o,
  input logic         pwr_up_o,
  input logic         sample_o,
  input logic         sclk_o,
  input logic         sdata_o,
  input logic [W-1:0] dac_code_o
);

  // R2: a start follows enable seen high through both synchronizer stages
  a_r2_start_needs_enable: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> $past(en_i, 3));

  // R3: power-up and busy fall together and leave the serial clock low
  a_r3_fall_clean: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> (!pwr_up_o && !sclk_o && !sdata_o));

  // R4: the hold window opens only after the power-up phase
  a_r4_sample_after_pwrup: assert property (@(posedge clk) disable iff (rst)
    $rose(sample_o) |-> $past(pwr_up_o) && $past(busy_o));

  // R5: the first trial code is mid-scale
  a_r5_mid_first: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> (dac_code_o == (W'(1) << (W - 1))));

  // R6: the result is held while idle
  a_r6_hold_idle: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && $past(!busy_o)) |-> $stable(dac_code_o));

  // R7: data does not move while the serial clock is high
  a_r7_data_stable_high: assert property (@(posedge clk) disable iff (rst)
    sclk_o |-> $stable(sdata_o));

  // R8: no serial clock outside a conversion
  a_r8_sclk_idle_low: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> !sclk_o);

endmodule

bind hk_adc_ctrl hk_adc_ctrl_chk #(.W(DATA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .en_i       (en_i),
  .busy_o     (busy_o),
  .pwr_up_o   (pwr_up_o),
  .sample_o   (sample_o),
  .sclk_o     (sclk_o),
  .sdata_o    (sdata_o),
  .dac_code_o (dac_code_o)
);

// File: tb/tb_hk_adc_ctrl.sv
`timescale 1ns/1ps
module tb_hk_adc_ctrl;

  localparam int W  = 8;
  localparam int D  = 8;
  localparam int P  = 5;
  localparam int S  = 3;
  localparam int B  = 2;
  localparam int C0 = P + S;
  localparam int S0 = C0 + W * B;
  localparam int TOTAL = S0 + W * D;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         en_i = 1'b0;
  logic         cmp_i;
  logic         pwr_up_o, sample_o, sclk_o, sdata_o, busy_o;
  logic [W-1:0] dac_code_o;
  int           vin = 0;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  // Analog front end: comparator against a held input level.
  assign cmp_i = (vin >= int'(dac_code_o));

  hk_adc_ctrl #(
    .DATA_W(W), .SCLK_DIV(D), .PWRUP_CYC(P), .SAMPLE_CYC(S),
    .BIT_CYC(B), .SYNC_STAGES(2)
  ) dut (
    .clk(clk), .rst(rst), .en_i(en_i), .cmp_i(cmp_i),
    .pwr_up_o(pwr_up_o), .sample_o(sample_o), .dac_code_o(dac_code_o),
    .sclk_o(sclk_o), .sdata_o(sdata_o), .busy_o(busy_o)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", tag, what, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // Behavioural reference: enable history, time since accept, held result.
  int  e1 = 0, e2 = 0, e3 = 0;
  bit  m_act = 0;
  int  t = 0;
  int  m_vin = 0;
  int  m_hold = 128;
  bit  cmp_on = 0;

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      e1 = 0; e2 = 0; e3 = 0;
      m_act = 0; t = 0; m_hold = 128;
    end else begin
      bit acc;
      acc = !m_act && (e2 == 1) && (e3 == 0);
      if (m_act) begin
        t++;
        if (t == TOTAL) begin
          m_act = 0;
          m_hold = m_vin;
        end
      end
      if (acc) begin
        m_act = 1;
        t = 0;
        m_vin = vin;
      end
      e3 = e2; e2 = e1; e1 = int'(en_i);
    end
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d cycles", cyc, 150000);
      finish_run();
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      int eb, es, ec, ek, ed;
      eb = m_act ? 1 : 0;
      es = (m_act && t >= P && t < C0) ? 1 : 0;
      ec = m_hold; ek = 0; ed = 0;
      if (m_act) begin
        if (t < C0) ec = 128;
        else if (t < S0) begin
          int k;
          k  = (t - C0) / B;
          ec = (m_vin & ~((1 << (W - k)) - 1) & 255) | (1 << (W - 1 - k));
        end else begin
          int j, ph;
          j  = (t - S0) / D;
          ph = (t - S0) % D;
          ec = m_vin;
          ed = (m_vin >> (W - 1 - j)) & 1;
          ek = (ph >= D / 2) ? 1 : 0;
        end
      end
      check("R3", "busy_o", int'(busy_o), eb);
      check("R3", "pwr_up_o", int'(pwr_up_o), eb);
      check("R4", "sample_o", int'(sample_o), es);
      if (m_act && t >= C0 && t < S0) check("R5", "dac_code_o trial", int'(dac_code_o), ec);
      else if (m_act && t < C0)      check("R5", "dac_code_o mid-scale", int'(dac_code_o), ec);
      else                           check("R6", "dac_code_o held", int'(dac_code_o), ec);
      check("R7", "sdata_o", int'(sdata_o), ed);
      check("R8", "sclk_o", int'(sclk_o), ek);
    end
  end

  task automatic wait_idle();
    int n = 0;
    while (busy_o && n < 1000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic convert(input int v);
    @(negedge clk);
    vin = v;
    en_i = 1'b1;
    repeat (2) @(negedge clk);
    check("R2", "busy_o before third edge", int'(busy_o), 0);
    @(negedge clk);
    check("R2", "busy_o after third edge", int'(busy_o), 1);
    wait_idle();
    check("R6", "final result", int'(dac_code_o), v);
    en_i = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "busy_o in reset", int'(busy_o), 0);
    check("R1", "pwr_up_o in reset", int'(pwr_up_o), 0);
    check("R1", "sample_o in reset", int'(sample_o), 0);
    check("R1", "sclk_o in reset", int'(sclk_o), 0);
    check("R1", "sdata_o in reset", int'(sdata_o), 0);
    check("R1", "dac_code_o in reset", int'(dac_code_o), 128);
    rst = 1'b0;
    @(negedge clk);
    cmp_on = 1;

    convert(8'h00);
    convert(8'hFF);
    convert(8'h80);
    convert(8'h7F);
    convert(8'h5A);
    convert(8'hA5);
    convert(8'h01);

    // R9: enable toggles mid-conversion are dropped.
    @(negedge clk);
    vin = 8'h3C;
    en_i = 1'b1;
    repeat (12) @(negedge clk);
    en_i = 1'b0;
    repeat (3) @(negedge clk);
    en_i = 1'b1;
    repeat (4) @(negedge clk);
    en_i = 1'b0;
    repeat (3) @(negedge clk);
    en_i = 1'b1;
    wait_idle();
    check("R9", "result of first request", int'(dac_code_o), 8'h3C);
    // R10: enable still high, so nothing restarts.
    repeat (20) begin
      @(negedge clk);
      check("R10", "busy_o with enable held high", int'(busy_o), 0);
    end
    vin = 8'hC3;
    en_i = 1'b0;
    repeat (3) @(negedge clk);
    en_i = 1'b1;
    repeat (3) @(negedge clk);
    check("R10", "busy_o after low then high", int'(busy_o), 1);
    wait_idle();
    check("R10", "result after restart", int'(dac_code_o), 8'hC3);
    en_i = 1'b0;
    repeat (4) @(negedge clk);

    // One-cycle enable pulse is still caught by the synchronizer.
    vin = 8'h69;
    en_i = 1'b1;
    @(negedge clk);
    en_i = 1'b0;
    repeat (2) @(negedge clk);
    check("R2", "busy_o after short pulse", int'(busy_o), 1);
    wait_idle();
    check("R6", "short pulse result", int'(dac_code_o), 8'h69);
    repeat (5) @(negedge clk);

    finish_run();
  end

endmodule